// File: doc/BRIEF.md
# Keypad Parameter Entry Controller

This block sits between a keypad scanner and the control logic of a power-converter board. Each key press arrives as a one-cycle strobe with a 4-bit code. The block turns these presses into a choice of operating mode and into edits of signed parameter registers. From the startup state the operator types a mode number and confirms it. Inside a mode, the operator moves through that mode's parameters, steps the selected one up or down, or types a decimal value and confirms it. A typed value is then converted to signed binary and stored.

Two keys change meaning with context. The minus key steps the parameter down when no entry is open, and it sets the sign when it is the first character of an open entry. The zero key is a digit inside an entry, and it clears the selected parameter when no entry is open. An entry opens when a non-zero digit is typed, or when confirm is pressed with nothing typed. The home key aborts from any state. The entry buffer (digits, length, sign) is brought out for a display driver. Every output is a register and changes one clock after the key is sampled.

Top module: `keypad_param_ctrl`

## Requirements
- R1: After reset: mode 0 (startup), selection 0, no entry open, length 0, sign clear, every parameter 0 and no write strobe.
- R2: Codes 1..9 append that digit to the entry and open it. Code 0 appends a zero only while an entry is open. Once 6 digits are held, further digits are ignored. The most recent digit sits in nibble 0 of `digits_o`.
- R3: In mode 0, confirm (code 11) with a typed value of 1, 2 or 3 and no sign enters open-loop (1), closed-loop (2) or three-phase (3) mode with selection 0. Any other typed value clears the entry and stays in mode 0.
- R4: In modes 1..3, confirm with at least one digit writes the signed value, clamped to the W-bit signed range, into parameter base+sel, pulses `wr_o` with `wr_idx_o` = base+sel, and closes the entry. The bases are 0 for mode 1, 2 for mode 2 and 11 for mode 3.
- R5: In modes 1..3, confirm with no entry open opens an empty entry. A minus (code 15) as its first character sets the sign, and a later commit stores a negative value.
- R6: In modes 1..3, code 0 with no entry open writes 0 to the selected parameter, with a write strobe.
- R7: Backspace (code 12) removes the last digit. When no digit is left it clears the sign. It never closes the entry.
- R8: Select (code 13), with no entry open, advances the selection and wraps to 0 after the mode's last parameter. The counts are 2, 9 and 1 for modes 1, 2 and 3. The selection is always below the count.
- R9: With no entry open, plus (code 14) and minus add or subtract 1 from the selected parameter, saturating at the W-bit signed limits, with a write strobe.
- R10: Home (code 10) from any state returns to mode 0 with selection 0 and the entry cleared. Stored parameters keep their values.
- R11: Nothing changes while `key_vld_i` is low, and `wr_o` is high only in the cycle after a sampled key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_vld_i | input | 1 | One-cycle key strobe |
| key_code_i | input | 4 | Key code: 0-9 digits, 10 home, 11 confirm, 12 backspace, 13 select, 14 plus, 15 minus |
| mode_o | output | 2 | Operating mode, 0 = startup |
| sel_o | output | 4 | Selected parameter within the mode |
| entry_o | output | 1 | Entry open |
| neg_o | output | 1 | Entry sign is negative |
| len_o | output | 3 | Digits held in the entry |
| digits_o | output | 24 | Entry digits in BCD, newest in nibble 0 |
| par_o | output | 12x20 | Committed signed parameter values |
| wr_o | output | 1 | One-cycle parameter write strobe |
| wr_idx_o | output | 4 | Index of the parameter last written |

## Verification
A wrong mode or selection register shows on `mode_o`/`sel_o` one cycle after the key. It also sends the next write to the wrong `wr_idx_o`, so a commit exposes it right away. A corrupted digit shift or a wrong count appears first on `digits_o`/`len_o`, and it becomes a wrong stored value on `par_o` at the next confirm. A broken saturation or sign path is visible only when a value is pushed to the signed limits or committed after a minus key, so those corners are driven deliberately.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam logic [3:0] K_HOME  = 4'd10;
  localparam logic [3:0] K_ENTER = 4'd11;
  localparam logic [3:0] K_BKSP  = 4'd12;
  localparam logic [3:0] K_SEL   = 4'd13;
  localparam logic [3:0] K_PLUS  = 4'd14;
  localparam logic [3:0] K_MINUS = 4'd15;

  typedef enum logic [1:0] {MD_HOME, MD_OPEN, MD_CLOSED, MD_VF} kp_mode_e;
  typedef enum logic [2:0] {OP_NONE, OP_LOAD, OP_INC, OP_DEC, OP_ZERO} kp_op_e;
endpackage

// File: rtl/kp_entry_buf.sv
module kp_entry_buf #(
  parameter int DIGS = 6,
  localparam int LENW = $clog2(DIGS + 1),
  localparam int VW = 4 * DIGS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_i,
  input  logic                 open_i,
  input  logic                 push_i,
  input  logic [3:0]           dig_i,
  input  logic                 pop_i,
  input  logic                 sign_i,
  output logic                 active_o,
  output logic                 neg_o,
  output logic [LENW-1:0]      len_o,
  output logic [VW-1:0]        digs_o,
  output logic signed [VW:0]   val_o
);
  logic [VW-1:0]     mag;
  logic signed [VW:0] smag;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      active_o <= 1'b0;
      neg_o    <= 1'b0;
      len_o    <= '0;
      digs_o   <= '0;
    end else begin
      if (open_i) active_o <= 1'b1;
      if (push_i) begin
        active_o <= 1'b1;
        if (len_o < LENW'(DIGS)) begin
          digs_o <= (digs_o << 4) | VW'(dig_i);
          len_o  <= len_o + 1'b1;
        end
      end
      if (pop_i) begin
        if (len_o != '0) begin
          digs_o <= digs_o >> 4;
          len_o  <= len_o - 1'b1;
        end else begin
          neg_o <= 1'b0;
        end
      end
      if (sign_i) begin
        neg_o    <= 1'b1;
        active_o <= 1'b1;
      end
    end
  end

  // BCD to binary, most significant digit first
  always_comb begin
    mag = '0;
    for (int i = DIGS - 1; i >= 0; i--)
      mag = (mag << 3) + (mag << 1) + VW'(digs_o[i*4 +: 4]);
    smag  = $signed({1'b0, mag});
    val_o = neg_o ? -smag : smag;
  end
endmodule

// File: rtl/kp_param_bank.sv
module kp_param_bank
  import kp_pkg::*;
#(
  parameter int NPAR = 12,
  parameter int W = 20,
  parameter int VW = 24,
  localparam int IDXW = $clog2(NPAR + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  kp_op_e                       op_i,
  input  logic [IDXW-1:0]              idx_i,
  input  logic signed [VW:0]           val_i,
  output logic [NPAR-1:0][W-1:0]       par_o,
  output logic                         wr_o,
  output logic [IDXW-1:0]              wr_idx_o
);
  localparam logic signed [W-1:0]  PMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  PMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [VW:0]   BMAX = (VW+1)'(PMAX);
  localparam logic signed [VW:0]   BMIN = (VW+1)'(PMIN);

  logic signed [W-1:0] par_q [NPAR];
  logic signed [W-1:0] cur, nxt;
  logic                wr_en;

  always_comb begin
    cur   = (idx_i < IDXW'(NPAR)) ? par_q[idx_i] : '0;
    wr_en = (op_i != OP_NONE) && (idx_i < IDXW'(NPAR));
    case (op_i)
      OP_LOAD: begin
        if (val_i > BMAX)      nxt = PMAX;
        else if (val_i < BMIN) nxt = PMIN;
        else                   nxt = val_i[W-1:0];
      end
      OP_INC:  nxt = (cur == PMAX) ? cur : cur + 1'b1;
      OP_DEC:  nxt = (cur == PMIN) ? cur : cur - 1'b1;
      default: nxt = '0;
    endcase
  end

  for (genvar g = 0; g < NPAR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) par_q[g] <= '0;
      else if (wr_en && idx_i == IDXW'(g)) par_q[g] <= nxt;
    end
    assign par_o[g] = par_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_o     <= 1'b0;
      wr_idx_o <= '0;
    end else begin
      wr_o <= wr_en;
      if (wr_en) wr_idx_o <= idx_i;
    end
  end
endmodule

// File: rtl/kp_ctrl.sv
module kp_ctrl
  import kp_pkg::*;
#(
  parameter int DIGS = 6,
  parameter int NOL = 2,
  parameter int NCL = 9,
  parameter int NVF = 1,
  localparam int NPAR = NOL + NCL + NVF,
  localparam int MAXC = (NOL > NCL) ? ((NOL > NVF) ? NOL : NVF) : ((NCL > NVF) ? NCL : NVF),
  localparam int SELW = $clog2(MAXC + 1),
  localparam int IDXW = $clog2(NPAR + 1),
  localparam int LENW = $clog2(DIGS + 1),
  localparam int VW = 4 * DIGS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                key_vld_i,
  input  logic [3:0]          key_code_i,
  input  logic                ent_active_i,
  input  logic                ent_neg_i,
  input  logic [LENW-1:0]     ent_len_i,
  input  logic signed [VW:0]  ent_val_i,
  output kp_mode_e            mode_o,
  output logic [SELW-1:0]     sel_o,
  output logic                clear_o,
  output logic                open_o,
  output logic                push_o,
  output logic                pop_o,
  output logic                sign_o,
  output kp_op_e              op_o,
  output logic [IDXW-1:0]     idx_o
);
  logic [SELW-1:0] cnt, base;
  kp_mode_e        mode_d;
  logic [SELW-1:0] sel_d;
  logic            is_digit, in_home;

  always_comb begin
    case (mode_o)
      MD_OPEN:   begin cnt = SELW'(NOL); base = '0;              end
      MD_CLOSED: begin cnt = SELW'(NCL); base = SELW'(NOL);       end
      MD_VF:     begin cnt = SELW'(NVF); base = SELW'(NOL + NCL); end
      default:   begin cnt = SELW'(1);   base = '0;              end
    endcase
    idx_o = IDXW'(base) + IDXW'(sel_o);
  end

  always_comb begin
    mode_d   = mode_o;
    sel_d    = sel_o;
    clear_o  = 1'b0;
    open_o   = 1'b0;
    push_o   = 1'b0;
    pop_o    = 1'b0;
    sign_o   = 1'b0;
    op_o     = OP_NONE;
    is_digit = key_code_i <= 4'd9;
    in_home  = mode_o == MD_HOME;
    if (key_vld_i) begin
      if (is_digit) begin
        if (ent_active_i || key_code_i != 4'd0) push_o = 1'b1;
        else if (!in_home)                      op_o   = OP_ZERO;
      end else begin
        case (key_code_i)
          K_HOME: begin
            clear_o = 1'b1;
            mode_d  = MD_HOME;
            sel_d   = '0;
          end
          K_ENTER: begin
            if (in_home) begin
              clear_o = ent_active_i;
              if (ent_len_i != '0 && !ent_neg_i && ent_val_i > 0 && ent_val_i < 4) begin
                mode_d = kp_mode_e'(ent_val_i[1:0]);
                sel_d  = '0;
              end
            end else if (!ent_active_i) begin
              open_o = 1'b1;
            end else begin
              clear_o = 1'b1;
              if (ent_len_i != '0) op_o = OP_LOAD;
            end
          end
          K_BKSP: pop_o = ent_active_i;
          K_SEL: if (!in_home && !ent_active_i)
            sel_d = (sel_o == cnt - 1'b1) ? '0 : sel_o + 1'b1;
          K_PLUS: if (!in_home && !ent_active_i) op_o = OP_INC;
          default: begin
            if (!in_home) begin
              if (!ent_active_i) op_o = OP_DEC;
              else if (ent_len_i == '0 && !ent_neg_i) sign_o = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MD_HOME;
      sel_o  <= '0;
    end else begin
      mode_o <= mode_d;
      sel_o  <= sel_d;
    end
  end
endmodule

// File: rtl/keypad_param_ctrl.sv
module keypad_param_ctrl
  import kp_pkg::*;
#(
  parameter int DIGS = 6,
  parameter int W = 20,
  parameter int NOL = 2,
  parameter int NCL = 9,
  parameter int NVF = 1,
  localparam int NPAR = NOL + NCL + NVF,
  localparam int MAXC = (NOL > NCL) ? ((NOL > NVF) ? NOL : NVF) : ((NCL > NVF) ? NCL : NVF),
  localparam int SELW = $clog2(MAXC + 1),
  localparam int IDXW = $clog2(NPAR + 1),
  localparam int LENW = $clog2(DIGS + 1),
  localparam int VW = 4 * DIGS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    key_vld_i,
  input  logic [3:0]              key_code_i,
  output logic [1:0]              mode_o,
  output logic [SELW-1:0]         sel_o,
  output logic                    entry_o,
  output logic                    neg_o,
  output logic [LENW-1:0]         len_o,
  output logic [VW-1:0]           digits_o,
  output logic [NPAR-1:0][W-1:0]  par_o,
  output logic                    wr_o,
  output logic [IDXW-1:0]         wr_idx_o
);
  kp_mode_e           mode;
  kp_op_e             op;
  logic [IDXW-1:0]    idx;
  logic               clr, opn, push, pop, sgn;
  logic signed [VW:0] val;

  kp_ctrl #(.DIGS(DIGS), .NOL(NOL), .NCL(NCL), .NVF(NVF)) u_ctrl (
    .clk(clk), .rst(rst), .key_vld_i(key_vld_i), .key_code_i(key_code_i),
    .ent_active_i(entry_o), .ent_neg_i(neg_o), .ent_len_i(len_o), .ent_val_i(val),
    .mode_o(mode), .sel_o(sel_o), .clear_o(clr), .open_o(opn), .push_o(push),
    .pop_o(pop), .sign_o(sgn), .op_o(op), .idx_o(idx)
  );

  kp_entry_buf #(.DIGS(DIGS)) u_buf (
    .clk(clk), .rst(rst), .clear_i(clr), .open_i(opn), .push_i(push),
    .dig_i(key_code_i), .pop_i(pop), .sign_i(sgn), .active_o(entry_o),
    .neg_o(neg_o), .len_o(len_o), .digs_o(digits_o), .val_o(val)
  );

  kp_param_bank #(.NPAR(NPAR), .W(W), .VW(VW)) u_bank (
    .clk(clk), .rst(rst), .op_i(op), .idx_i(idx), .val_i(val),
    .par_o(par_o), .wr_o(wr_o), .wr_idx_o(wr_idx_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/kp_chk.sv
module kp_chk
  import kp_pkg::*;
#(
  parameter int DIGS = 6, parameter int W = 20,
  parameter int NOL = 2, parameter int NCL = 9, parameter int NVF = 1,
  parameter int NPAR = 12, parameter int SELW = 4, parameter int LENW = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   key_vld_i,
  input logic [3:0]             key_code_i,
  input logic [1:0]             mode_o,
  input logic [SELW-1:0]        sel_o,
  input logic                   entry_o,
  input logic                   neg_o,
  input logic [LENW-1:0]        len_o,
  input logic [NPAR-1:0][W-1:0] par_o,
  input logic                   wr_o
);
  function automatic int count_of(logic [1:0] m);
    case (m)
      2'd1:    return NOL;
      2'd2:    return NCL;
      2'd3:    return NVF;
      default: return 1;
    endcase
  endfunction

  // R11
  wr_after_key_chk: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> $past(key_vld_i));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !key_vld_i |=> !wr_o && $stable(mode_o) && $stable(par_o));
  // R10
  home_abort_chk: assert property (@(posedge clk) disable iff (rst)
    key_vld_i && key_code_i == K_HOME |=> mode_o == 2'd0 && sel_o == '0 && !entry_o && len_o == '0);
  // R8
  sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(sel_o) < count_of(mode_o));
  // R2
  len_cap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(len_o) <= DIGS);
  // R5
  sign_in_entry_chk: assert property (@(posedge clk) disable iff (rst)
    neg_o |-> entry_o);
endmodule

bind keypad_param_ctrl kp_chk #(
  .DIGS(DIGS), .W(W), .NOL(NOL), .NCL(NCL), .NVF(NVF),
  .NPAR(NPAR), .SELW(SELW), .LENW(LENW)
) u_kp_chk (
  .clk(clk), .rst(rst), .key_vld_i(key_vld_i), .key_code_i(key_code_i),
  .mode_o(mode_o), .sel_o(sel_o), .entry_o(entry_o), .neg_o(neg_o),
  .len_o(len_o), .par_o(par_o), .wr_o(wr_o)
);

// File: tb/test_keypad_param_ctrl.sv
module test_keypad_param_ctrl;
  localparam int HOME = 10, ENT = 11, BK = 12, SEL = 13, PLUS = 14, MIN = 15;
  localparam int PMAX = 524287, PMIN = -524288;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              key_vld = 1'b0;
  logic [3:0]        key_code = '0;
  logic [1:0]        mode;
  logic [3:0]        sel;
  logic              entry, neg;
  logic [2:0]        len;
  logic [23:0]       digits;
  logic [11:0][19:0] par;
  logic              wr;
  logic [3:0]        wr_idx;

  int total = 0;
  int bad = 0;

  typedef struct {
    int m, s, en, ng, ln, w, idx, val, dg;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  keypad_param_ctrl i_keypad_param_ctrl (
    .clk(clk), .rst(rst), .key_vld_i(key_vld), .key_code_i(key_code),
    .mode_o(mode), .sel_o(sel), .entry_o(entry), .neg_o(neg), .len_o(len),
    .digits_o(digits), .par_o(par), .wr_o(wr), .wr_idx_o(wr_idx)
  );

  function automatic int parv(int i);
    logic signed [19:0] v;
    v = par[i];
    return int'(v);
  endfunction

  task automatic press(int code, int m, int s, int en, int ng, int ln,
                       int w, int idx, int val, int dg, string tag);
    exp_t e;
    e = '{m, s, en, ng, ln, w, idx, val, dg, tag};
    @(negedge clk);
    q.push_back(e);
    key_code = 4'(code);
    key_vld  = 1'b1;
    @(negedge clk);
    key_vld = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pop one expectation per sampled key, compare after the edge
  initial begin
    exp_t e;
    bit   ok;
    forever begin
      @(posedge clk);
      if (key_vld) begin
        #2;
        e  = q.pop_front();
        ok = (int'(mode) == e.m) && (int'(sel) == e.s) && (int'(entry) == e.en) &&
             (int'(neg) == e.ng) && (int'(len) == e.ln) && (int'(wr) == e.w);
        if (e.w != 0 && int'(wr_idx) != e.idx) ok = 0;
        if (e.idx >= 0 && parv(e.idx) != e.val) ok = 0;
        if (e.dg >= 0 && int'(digits) != e.dg) ok = 0;
        total++;
        if (!ok) begin
          bad++;
          $display("FAIL %s: got mode=%0d sel=%0d ent=%0d neg=%0d len=%0d wr=%0d idx=%0d val=%0d dig=%h exp mode=%0d sel=%0d ent=%0d neg=%0d len=%0d wr=%0d idx=%0d val=%0d dig=%h",
                   e.tag, mode, sel, entry, neg, len, wr, wr_idx,
                   (e.idx >= 0) ? parv(e.idx) : 0, digits,
                   e.m, e.s, e.en, e.ng, e.ln, e.w, e.idx, e.val, e.dg);
        end
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    ok = (mode == 0) && (sel == 0) && !entry && !neg && (len == 0) && !wr && (par == '0);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R1: got mode=%0d sel=%0d ent=%0d len=%0d wr=%0d exp all zero", mode, sel, entry, len, wr);
    end

    // R2 / R3 in startup
    press(7,   0, 0, 1, 0, 1, 0, -1, 0, 'h7, "R2 digit in home");
    press(ENT, 0, 0, 0, 0, 0, 0, -1, 0, 0,   "R3 invalid mode");
    press(2,   0, 0, 1, 0, 1, 0, -1, 0, 'h2, "R2 digit 2");
    press(ENT, 2, 0, 0, 0, 0, 0, -1, 0, -1,  "R3 closed-loop mode");

    // R8 selection wraps after 9
    for (int k = 1; k <= 9; k++)
      press(SEL, 2, k % 9, 0, 0, 0, 0, -1, 0, -1, "R8 select wrap");

    // R7 backspace, R4 commit into index 2
    press(1,   2, 0, 1, 0, 1, 0, -1, 0, 'h1,   "R2 digit 1");
    press(2,   2, 0, 1, 0, 2, 0, -1, 0, 'h12,  "R2 digit 2");
    press(3,   2, 0, 1, 0, 3, 0, -1, 0, 'h123, "R2 digit 3");
    press(BK,  2, 0, 1, 0, 2, 0, -1, 0, 'h12,  "R7 remove last");
    press(ENT, 2, 0, 0, 0, 0, 1, 2, 12, 0,     "R4 commit 12");

    // R9 step
    press(PLUS, 2, 0, 0, 0, 0, 1, 2, 13, -1, "R9 plus");
    press(MIN,  2, 0, 0, 0, 0, 1, 2, 12, -1, "R9 minus");

    // R5 sign, R7 sign removal
    press(ENT, 2, 0, 1, 0, 0, 0, 2, 12, 0,  "R5 open entry");
    press(MIN, 2, 0, 1, 1, 0, 0, 2, 12, 0,  "R5 sign");
    press(4,   2, 0, 1, 1, 1, 0, -1, 0, 'h4, "R2 digit 4");
    press(5,   2, 0, 1, 1, 2, 0, -1, 0, 'h45, "R2 digit 5");
    press(BK,  2, 0, 1, 1, 1, 0, -1, 0, 'h4, "R7 pop digit");
    press(BK,  2, 0, 1, 1, 0, 0, -1, 0, 0,  "R7 pop last digit");
    press(BK,  2, 0, 1, 0, 0, 0, -1, 0, 0,  "R7 clear sign");
    press(MIN, 2, 0, 1, 1, 0, 0, -1, 0, 0,  "R5 sign again");
    press(4,   2, 0, 1, 1, 1, 0, -1, 0, 'h4, "R2 digit 4");
    press(5,   2, 0, 1, 1, 2, 0, -1, 0, 'h45, "R2 digit 5");
    press(ENT, 2, 0, 0, 0, 0, 1, 2, -45, 0, "R5 negative commit");

    // R6 zero as reset
    press(0,   2, 0, 0, 0, 0, 1, 2, 0, 0,   "R6 zero resets");

    // R10 home retains parameters; zero as digit inside entry
    press(ENT, 2, 0, 1, 0, 0, 0, -1, 0, 0,  "R5 open entry");
    press(8,   2, 0, 1, 0, 1, 0, -1, 0, 'h8, "R2 digit 8");
    press(ENT, 2, 0, 0, 0, 0, 1, 2, 8, 0,   "R4 commit 8");
    press(ENT, 2, 0, 1, 0, 0, 0, -1, 0, 0,  "R5 open entry");
    press(0,   2, 0, 1, 0, 1, 0, 2, 8, 0,   "R2 zero digit in entry");
    press(HOME, 0, 0, 0, 0, 0, 0, 2, 8, 0,  "R10 home keeps params");

    // open-loop: full buffer and positive clamp/saturation
    press(1,   0, 0, 1, 0, 1, 0, -1, 0, 'h1, "R2 digit 1");
    press(ENT, 1, 0, 0, 0, 0, 0, -1, 0, -1, "R3 open-loop mode");
    for (int k = 1; k <= 6; k++)
      press(9, 1, 0, 1, 0, k, 0, -1, 0, -1, "R2 fill");
    press(9,   1, 0, 1, 0, 6, 0, -1, 0, 'h999999, "R2 full ignored");
    press(ENT, 1, 0, 0, 0, 0, 1, 0, PMAX, 0, "R4 clamp high");
    press(PLUS, 1, 0, 0, 0, 0, 1, 0, PMAX, -1, "R9 saturate high");
    press(MIN,  1, 0, 0, 0, 0, 1, 0, PMAX - 1, -1, "R9 minus");

    // negative clamp and saturation
    press(ENT, 1, 0, 1, 0, 0, 0, -1, 0, 0, "R5 open entry");
    press(MIN, 1, 0, 1, 1, 0, 0, -1, 0, 0, "R5 sign");
    for (int k = 1; k <= 6; k++)
      press(9, 1, 0, 1, 1, k, 0, -1, 0, -1, "R2 fill neg");
    press(ENT, 1, 0, 0, 0, 0, 1, 0, PMIN, 0, "R4 clamp low");
    press(MIN, 1, 0, 0, 0, 0, 1, 0, PMIN, -1, "R9 saturate low");

    // R11 keys with strobe low are ignored
    @(negedge clk);
    key_code = 4'(PLUS);
    key_vld  = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (wr || mode != 2'd1 || parv(0) != PMIN) begin
      bad++;
      $display("FAIL R11: got wr=%0d mode=%0d val=%0d exp wr=0 mode=1 val=%0d", wr, mode, parv(0), PMIN);
    end

    // three-phase mode: single parameter at index 11
    press(HOME, 0, 0, 0, 0, 0, 0, -1, 0, -1, "R10 home");
    press(3,    0, 0, 1, 0, 1, 0, -1, 0, 'h3, "R2 digit 3");
    press(ENT,  3, 0, 0, 0, 0, 0, -1, 0, -1, "R3 three-phase mode");
    press(SEL,  3, 0, 0, 0, 0, 0, -1, 0, -1, "R8 single param wrap");
    press(PLUS, 3, 0, 0, 0, 0, 1, 11, 1, -1, "R9 plus at base 11");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule